// File: doc/BRIEF.md
# I/Q Converter Parallel Bridge

This block joins an 8-bit host sample bus to a dual-channel I/Q converter pair: an ADC on the receive side and a 10-bit DAC on the transmit side. It runs from a system clock at twice the converter rate. It produces the converter clock itself as a register that toggles on every system edge. The first half of each converter period, with the clock high, carries the I channel. The second half, with the clock low, carries the Q channel. So one converter sample moves per half period, and I and Q alternate on the host bus.

In receive mode the bridge captures the ADC byte on each system edge. A byte taken while the converter clock is high is the I sample that became valid after the rising edge. A byte taken while it is low is the Q sample that became valid after the falling edge. Each byte is presented on the host bus together with a channel flag, and the Q byte can optionally be complemented. In transmit mode the host byte is loaded into the upper eight DAC bits. The byte loaded at a rising converter edge goes to the Q slot and the byte loaded at a falling edge goes to the I slot. A disable input parks the stream. A direction input picks the mode and also controls whether the host bus is driven.

Top module: `codec_iq_bridge`

## Requirements
- R1: While `stream_off_i` is low, `codec_clk_o` inverts on every `clk_i` rising edge. While `stream_off_i` is high, it goes low at the next edge and stays low. After reset it is low, so the first enabled edge drives it high (a rising converter edge).
- R2: In receive mode (`tx_mode_i`=0) and while enabled, the ADC byte sampled at an edge where `codec_clk_o` was high appears unchanged on `host_data_o` after that edge, with `host_is_q_o`=0 (I channel).
- R3: In receive mode and while enabled, the ADC byte sampled at an edge where `codec_clk_o` was low appears on `host_data_o` after that edge, with `host_is_q_o`=1 (Q channel).
- R4: When `q_invert_i`=1, a Q byte on the receive path is the bitwise complement of the ADC byte. I bytes are never altered, and `q_invert_i` has no effect on the DAC word.
- R5: In transmit mode (`tx_mode_i`=1) and while enabled, each edge loads `dac_data_o` = {`host_data_i`, 2'b00}, so the host byte drives DAC bits 9..2 and bits 1..0 are zero. `dac_is_q_o` is 1 when the load coincides with a rising converter edge (`codec_clk_o` low before the edge) and 0 otherwise.
- R6: While `stream_off_i` is high, the next edge sets `host_data_o`=0, `host_is_q_o`=0, `dac_is_q_o`=0, and `dac_data_o` to the mid-scale idle code 10'h200.
- R7: `host_data_oe_o` is the registered inverse of `tx_mode_i`. The host bus is driven only in receive mode.
- R8: The path that is not selected is parked. In receive mode `dac_data_o` holds 10'h200 with `dac_is_q_o`=0. In transmit mode `host_data_o` holds 0 with `host_is_q_o`=0.
- R9: While `rst_ni` is low (asynchronous, active low), the outputs are `codec_clk_o`=0, `host_data_o`=0, `host_is_q_o`=0, `host_data_oe_o`=0, `dac_data_o`=10'h200 and `dac_is_q_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, twice the converter rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_mode_i | input | 1 | 1 = transmit (host to DAC), 0 = receive (ADC to host) |
| stream_off_i | input | 1 | 1 = stream stopped, 0 = streaming |
| q_invert_i | input | 1 | Complement Q bytes on the receive path |
| adc_data_i | input | 8 | Interleaved ADC output byte |
| host_data_i | input | 8 | Host byte for the DAC |
| codec_clk_o | output | 1 | Converter clock |
| host_data_o | output | 8 | Captured byte toward the host |
| host_data_oe_o | output | 1 | Drive enable of the host bus |
| host_is_q_o | output | 1 | Byte on host_data_o is Q |
| dac_data_o | output | 10 | DAC word |
| dac_is_q_o | output | 1 | DAC word occupies the Q slot |

## Verification
The properties assume that `tx_mode_i`, `stream_off_i`, `q_invert_i` and both data inputs are stable around each rising `clk_i` edge. They treat those inputs as synchronous to `clk_i`. The bench meets this by changing every input on the falling edge and sampling outputs on the following falling edge. Mode, disable and invert changes happen only at those instants, including the switch from receive to transmit with the converter clock mid-period.

// File: rtl/codec_iq_bridge_pkg.sv
package codec_iq_bridge_pkg;
  typedef enum logic {
    CH_I = 1'b0,
    CH_Q = 1'b1
  } chan_e;

  function automatic logic [15:0] mid_code(input int unsigned w);
    logic [15:0] v;
    v = '0;
    v[w-1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/codec_phase_gen.sv
module codec_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic phase_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= 1'b0;
    else if (!run_i) phase_q <= 1'b0;
    else             phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/codec_rx_path.sv
module codec_rx_path
  import codec_iq_bridge_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          phase_i,
  input  logic          q_invert_i,
  input  logic [DW-1:0] adc_i,
  output logic [DW-1:0] data_o,
  output logic          is_q_o
);
  chan_e         chan;
  logic [DW-1:0] byte_d;
  logic [DW-1:0] data_q;
  chan_e         chan_q;

  // clock high -> I is valid, clock low -> Q is valid
  assign chan   = phase_i ? CH_I : CH_Q;
  assign byte_d = (chan == CH_Q && q_invert_i) ? ~adc_i : adc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      chan_q <= CH_I;
    end else if (!run_i) begin
      data_q <= '0;
      chan_q <= CH_I;
    end else begin
      data_q <= byte_d;
      chan_q <= chan;
    end
  end

  assign data_o = data_q;
  assign is_q_o = (chan_q == CH_Q);
endmodule

// File: rtl/codec_tx_path.sv
module codec_tx_path
  import codec_iq_bridge_pkg::*;
#(
  parameter int unsigned HW = 8,
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          phase_i,
  input  logic [HW-1:0] host_i,
  output logic [DW-1:0] dac_o,
  output logic          is_q_o
);
  localparam int unsigned PAD = DW - HW;
  localparam logic [15:0] MID16 = mid_code(DW);
  localparam logic [DW-1:0] IDLE = MID16[DW-1:0];

  logic [DW-1:0] dac_q;
  chan_e         chan_q;
  logic [DW-1:0] word_d;

  generate
    if (PAD > 0) begin : g_pad
      assign word_d = {host_i, {PAD{1'b0}}};
    end else begin : g_nopad
      assign word_d = host_i[HW-1 -: DW];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q  <= IDLE;
      chan_q <= CH_I;
    end else if (!run_i) begin
      dac_q  <= IDLE;
      chan_q <= CH_I;
    end else begin
      dac_q  <= word_d;
      // load at rising converter edge feeds the Q slot
      chan_q <= phase_i ? CH_I : CH_Q;
    end
  end

  assign dac_o  = dac_q;
  assign is_q_o = (chan_q == CH_Q);
endmodule

// File: rtl/codec_iq_bridge.sv
module codec_iq_bridge #(
  parameter int unsigned HOST_W = 8,
  parameter int unsigned DAC_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_mode_i,
  input  logic              stream_off_i,
  input  logic              q_invert_i,
  input  logic [HOST_W-1:0] adc_data_i,
  input  logic [HOST_W-1:0] host_data_i,
  output logic              codec_clk_o,
  output logic [HOST_W-1:0] host_data_o,
  output logic              host_data_oe_o,
  output logic              host_is_q_o,
  output logic [DAC_W-1:0]  dac_data_o,
  output logic              dac_is_q_o
);
  logic run, rx_run, tx_run, phase, oe_q;

  assign run    = ~stream_off_i;
  assign rx_run = run & ~tx_mode_i;
  assign tx_run = run &  tx_mode_i;

  codec_phase_gen i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .phase_o(phase)
  );

  codec_rx_path #(.DW(HOST_W)) i_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (rx_run),
    .phase_i   (phase),
    .q_invert_i(q_invert_i),
    .adc_i     (adc_data_i),
    .data_o    (host_data_o),
    .is_q_o    (host_is_q_o)
  );

  codec_tx_path #(.HW(HOST_W), .DW(DAC_W)) i_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tx_run),
    .phase_i(phase),
    .host_i (host_data_i),
    .dac_o  (dac_data_o),
    .is_q_o (dac_is_q_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= ~tx_mode_i;
  end

  assign codec_clk_o    = phase;
  assign host_data_oe_o = oe_q;
endmodule

// File: rtl/codec_iq_bridge_chk.sv
module codec_iq_bridge_chk #(
  parameter int unsigned HOST_W = 8,
  parameter int unsigned DAC_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_mode_i,
  input logic              stream_off_i,
  input logic              q_invert_i,
  input logic [HOST_W-1:0] adc_data_i,
  input logic [HOST_W-1:0] host_data_i,
  input logic              codec_clk_o,
  input logic [HOST_W-1:0] host_data_o,
  input logic              host_data_oe_o,
  input logic              host_is_q_o,
  input logic [DAC_W-1:0]  dac_data_o,
  input logic              dac_is_q_o
);
  localparam logic [DAC_W-1:0] IDLE = {1'b1, {(DAC_W-1){1'b0}}};

  assert_clk_toggle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stream_off_i |=> codec_clk_o != $past(codec_clk_o));

  assert_clk_parked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stream_off_i |=> !codec_clk_o);

  assert_rx_i_tag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_mode_i && !stream_off_i && codec_clk_o) |=> !host_is_q_o && host_data_o == $past(adc_data_i));

  assert_rx_q_tag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_mode_i && !stream_off_i && !codec_clk_o) |=> host_is_q_o);

  assert_q_invert_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_mode_i && !stream_off_i && !codec_clk_o && q_invert_i) |=> host_data_o == ~$past(adc_data_i));

  assert_tx_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_mode_i && !stream_off_i) |=> dac_data_o[DAC_W-1 -: HOST_W] == $past(host_data_i));

  assert_tx_low_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_data_o[DAC_W-HOST_W-1:0] == '0);

  assert_stream_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stream_off_i |=> host_data_o == '0 && dac_data_o == IDLE && !dac_is_q_o && !host_is_q_o);

  assert_bus_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> host_data_oe_o == !$past(tx_mode_i));

  assert_parked_path_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_mode_i |=> host_data_o == '0);
endmodule

bind codec_iq_bridge codec_iq_bridge_chk #(.HOST_W(HOST_W), .DAC_W(DAC_W)) i_chk (.*);

// File: tb/test_codec_iq_bridge.sv
module test_codec_iq_bridge;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_mode_i = 1'b0, stream_off_i = 1'b0, q_invert_i = 1'b0;
  logic [7:0] adc_data_i = '0, host_data_i = '0;
  logic       codec_clk_o, host_data_oe_o, host_is_q_o, dac_is_q_o;
  logic [7:0] host_data_o;
  logic [9:0] dac_data_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  codec_iq_bridge i_codec_iq_bridge (.*);

  // {tx, off, qinv, adc, host, exp_host, exp_hq, exp_dac, exp_dq, exp_clk, exp_oe}
  localparam int NV = 12;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,8'h11,8'h00, 8'h11,1'b1,10'h200,1'b0,1'b1,1'b1},
    {1'b0,1'b0,1'b0,8'h22,8'h00, 8'h22,1'b0,10'h200,1'b0,1'b0,1'b1},
    {1'b0,1'b0,1'b1,8'h33,8'h00, 8'hCC,1'b1,10'h200,1'b0,1'b1,1'b1},
    {1'b0,1'b0,1'b1,8'h44,8'h00, 8'h44,1'b0,10'h200,1'b0,1'b0,1'b1},
    {1'b0,1'b1,1'b0,8'h55,8'h00, 8'h00,1'b0,10'h200,1'b0,1'b0,1'b1},
    {1'b0,1'b0,1'b0,8'h66,8'h00, 8'h66,1'b1,10'h200,1'b0,1'b1,1'b1},
    {1'b1,1'b0,1'b0,8'h77,8'hA5, 8'h00,1'b0,10'h294,1'b0,1'b0,1'b0},
    {1'b1,1'b0,1'b0,8'h77,8'h5A, 8'h00,1'b0,10'h168,1'b1,1'b1,1'b0},
    {1'b1,1'b0,1'b1,8'h77,8'hFF, 8'h00,1'b0,10'h3FC,1'b0,1'b0,1'b0},
    {1'b1,1'b0,1'b1,8'h77,8'h80, 8'h00,1'b0,10'h200,1'b1,1'b1,1'b0},
    {1'b1,1'b1,1'b0,8'h77,8'h12, 8'h00,1'b0,10'h200,1'b0,1'b0,1'b0},
    {1'b1,1'b0,1'b0,8'h77,8'h01, 8'h00,1'b0,10'h004,1'b1,1'b1,1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_reset_state(input string tag);
    check({tag, " R9 codec_clk"}, 32'(codec_clk_o), 32'h0);
    check({tag, " R9 host_data"}, 32'(host_data_o), 32'h0);
    check({tag, " R9 host_oe"},   32'(host_data_oe_o), 32'h0);
    check({tag, " R9 host_is_q"}, 32'(host_is_q_o), 32'h0);
    check({tag, " R9 dac_data"},  32'(dac_data_o), 32'h200);
    check({tag, " R9 dac_is_q"},  32'(dac_is_q_o), 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk_i);
    check_reset_state("reset");
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      tx_mode_i    = v[40];
      stream_off_i = v[39];
      q_invert_i   = v[38];
      adc_data_i   = v[37:30];
      host_data_i  = v[29:22];
      @(negedge clk_i);
      check($sformatf("vec%0d R2 R3 R4 R6 R8 host_data", i), 32'(host_data_o), 32'(v[21:14]));
      check($sformatf("vec%0d R2 R3 host_is_q", i),          32'(host_is_q_o), 32'(v[13]));
      check($sformatf("vec%0d R5 R6 R8 dac_data", i),        32'(dac_data_o), 32'(v[12:3]));
      check($sformatf("vec%0d R5 dac_is_q", i),              32'(dac_is_q_o), 32'(v[2]));
      check($sformatf("vec%0d R1 codec_clk", i),             32'(codec_clk_o), 32'(v[1]));
      check($sformatf("vec%0d R7 host_oe", i),               32'(host_data_oe_o), 32'(v[0]));
    end

    // R1: held disable keeps the converter clock low over several edges
    stream_off_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      check("R1 parked clock", 32'(codec_clk_o), 32'h0);
    end

    // R5: DAC low bits stay zero for an all-ones host byte
    stream_off_i = 1'b0;
    host_data_i  = 8'hFF;
    @(negedge clk_i);
    check("R5 low bits zero", 32'(dac_data_o[1:0]), 32'h0);
    check("R5 top bits", 32'(dac_data_o[9:2]), 32'hFF);

    // R7: switch back to receive raises bus enable one edge later
    tx_mode_i  = 1'b0;
    adc_data_i = 8'h9C;
    check("R7 oe before edge", 32'(host_data_oe_o), 32'h0);
    @(negedge clk_i);
    check("R7 oe after edge", 32'(host_data_oe_o), 32'h1);
    check("R8 dac idle in rx", 32'(dac_data_o), 32'h200);

    // R9: asynchronous reset mid stream
    #1 rst_ni = 1'b0;
    #0.5;
    check_reset_state("async");
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule